// File: doc/BRIEF.md
# Converter-to-Lane Transport Frame Mapper

This block takes one beat of parallel converter data and lays it out as a single transport frame spread over a group of serial-link lanes. A beat carries S samples from each of M converters. Each sample is N bits wide and may carry up to three user control bits, such as range or trigger flags. The block wraps every sample in a container that is a whole number of nibbles. It places the containers one after another in the frame, pads the unused space with zeros, and presents the frame as L lane words of F octets each.

Two elaboration-time options shape the layout:

- **High-density packing.** This decides whether a container may straddle a lane boundary. When it may not, the rest of that lane is zero-padded and the next sample starts on the next lane.
- **Grouped control.** This removes the control bits from the sample containers and collects them into a control word at the tail of the frame.

A valid/ready pair moves one frame per accepted beat, with a registered latency of one cycle. Parameter sets that do not fit in L×F×8 bits are rejected at elaboration.

Top module: `xport_frame_mapper`

## Requirements
- R1: Sample k of converter c is sample index i = c·S + k. It is read from `in_samples[i*N +: N]`, and containers are placed in increasing i.
- R2: With grouped control off, a container is the sample (MSB first), then its control bits from `in_ctrl[i*CSW +: CS]` (highest bit first), then zero tail bits. The container width is N+CS rounded up to a multiple of 4.
- R3: With high-density packing off, a container never crosses a lane boundary. The remainder of a lane that cannot hold a whole container is zero, and the next container starts at the first bit of the next lane.
- R4: With high-density packing on, container i starts at frame bit i×W, where W is the container width. A container that does not fit continues on the next lane.
- R5: With grouped control on, containers hold only the sample, rounded up to a nibble. All control bits are packed in sample order, highest bit first, into a word of whole octets that ends at the last frame bit. Its unused low bits are zero.
- R6: Frame bits that hold no sample or control bit are zero, including lanes that carry no data.
- R7: Frame bit 0 is `out_lanes[L*F*8-1]`. Lane j is `out_lanes[(L-j)*F*8-1 -: F*8]`, so lane 0 holds the first F octets and each lane's first octet is its top byte.
- R8: A beat accepted when `in_valid` and `in_ready` are both high appears on `out_lanes`, with `out_valid` high, after one clock edge. `in_ready` is high whenever the output register is empty or being read.
- R9: While `out_valid` is high and `out_ready` is low, `out_lanes` and `out_valid` hold, `in_ready` is low, and offered beats are not taken.
- R10: During and after reset, `out_valid` is low.
- R11: When CS is 0, `in_ctrl` has no effect on `out_lanes`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat can be taken |
| in_samples | input | M·S·N | All samples of the beat, sample i at bits i·N |
| in_ctrl | input | M·S·max(CS,1) | Control bits, sample i at bits i·max(CS,1) |
| out_valid | output | 1 | Frame present on the lanes |
| out_ready | input | 1 | Downstream takes the frame |
| out_lanes | output | L·F·8 | Frame, lane 0 in the top F octets |

## Verification
The bench drives inputs on the falling edge. Every mapped frame is due exactly one rising edge after the beat is accepted, so each frame is compared at the next falling edge together with `out_valid`. Back-pressure scenarios keep `out_ready` low for several cycles and compare the held frame and `in_ready` at each falling edge in that window. They then confirm that the pending beat lands one edge after `out_ready` returns. Three instances with different packing options are each checked against frames assembled in the bench from the requirement text.

// File: rtl/xfm_pkg.sv
package xfm_pkg;

   // Container width: sample plus in-container control bits, rounded up to a nibble
   function automatic int cont_w(int n, int cs, int cf);
      int w;
      w = n + ((cf != 0) ? 0 : cs);
      return ((w + 3) / 4) * 4;
   endfunction

   // Width of the grouped control word, whole octets
   function automatic int ctlword_w(int ns, int cs, int cf);
      if (cf == 0 || cs == 0) return 0;
      return ((ns * cs + 7) / 8) * 8;
   endfunction

   // Containers per lane when no straddling is allowed
   function automatic int per_lane(int lb, int np);
      return lb / np;
   endfunction

   // Frame bit offset at which container i starts
   function automatic int samp_pos(int i, int np, int lb, int hd);
      int spl;
      if (hd != 0) return i * np;
      spl = lb / np;
      if (spl == 0) return 0;
      return (i / spl) * lb + (i % spl) * np;
   endfunction

   // One past the last frame bit used by containers
   function automatic int used_end(int ns, int np, int lb, int hd);
      return samp_pos(ns - 1, np, lb, hd) + np;
   endfunction

endpackage

// File: rtl/xfm_container.sv
module xfm_container #(
   parameter int N   = 14,
   parameter int CS  = 2,
   parameter int CSW = 2,
   parameter int CF  = 0,
   parameter int NP  = 16
) (
   input  logic [N-1:0]   smp,
   input  logic [CSW-1:0] ctl,
   output logic [NP-1:0]  cont
);
   localparam int CIN = (CF == 0) ? CS : 0;
   localparam int PW  = N + CIN;

   logic [PW-1:0] payload;

   generate
      if (CIN > 0) begin : g_with_ctl
         assign payload = {smp, ctl[CS-1:0]};
      end else begin : g_no_ctl
         logic unused_ctl;
         assign unused_ctl = ^ctl;
         assign payload    = smp;
      end

      if (NP > PW) begin : g_tail
         assign cont = {payload, {(NP-PW){1'b0}}};
      end else begin : g_exact
         assign cont = payload;
      end
   endgenerate

endmodule

// File: rtl/xfm_assembler.sv
module xfm_assembler
   import xfm_pkg::*;
#(
   parameter int NS  = 2,
   parameter int NP  = 16,
   parameter int CS  = 2,
   parameter int CSW = 2,
   parameter int LB  = 16,
   parameter int FB  = 32,
   parameter int HD  = 0,
   parameter int CWW = 0
) (
   input  logic [NS*NP-1:0]  cont_flat,
   input  logic [NS*CSW-1:0] ctl_flat,
   output logic [FB-1:0]     frame
);
   localparam int CW_START = FB - CWW;

   logic [FB-1:0] smp_part;
   logic [FB-1:0] ctl_part;

   // Frame bit p maps to vector bit FB-1-p
   always_comb begin
      smp_part = '0;
      for (int i = 0; i < NS; i++) begin
         smp_part[FB-1-samp_pos(i, NP, LB, HD) -: NP] = cont_flat[i*NP +: NP];
      end
   end

   generate
      if (CWW > 0) begin : g_ctlword
         always_comb begin
            ctl_part = '0;
            for (int i = 0; i < NS; i++) begin
               for (int b = 0; b < CS; b++) begin
                  ctl_part[FB-1-CW_START-i*CS-b] = ctl_flat[i*CSW+CS-1-b];
               end
            end
         end
      end else begin : g_no_ctlword
         logic unused_ctlbits;
         assign unused_ctlbits = ^ctl_flat;
         assign ctl_part       = '0;
      end
   endgenerate

   assign frame = smp_part | ctl_part;

endmodule

// File: rtl/xfm_out_stage.sv
module xfm_out_stage #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   logic take;

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         if (in_ready) out_valid <= in_valid;
         if (take)     out_data  <= in_data;
      end
   end

   p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> out_valid);

   p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (out_data == $past(in_data)));

   p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !in_valid) |=> !out_valid);

   p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/xport_frame_mapper.sv
module xport_frame_mapper
   import xfm_pkg::*;
#(
   parameter int M  = 2,
   parameter int S  = 1,
   parameter int N  = 13,
   parameter int CS = 2,
   parameter int L  = 3,
   parameter int F  = 3,
   parameter int HD = 0,
   parameter int CF = 0,
   localparam int NS  = M * S,
   localparam int CSW = (CS > 0) ? CS : 1,
   localparam int FB  = L * F * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [NS*N-1:0]   in_samples,
   input  logic [NS*CSW-1:0] in_ctrl,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [FB-1:0]     out_lanes
);
   localparam int NP  = cont_w(N, CS, CF);
   localparam int LB  = F * 8;
   localparam int CWW = ctlword_w(NS, CS, CF);

   // Reject parameter sets that cannot be built
   generate
      if (CS < 0 || CS > 3) begin : g_bad_cs
         $error("control bits per sample must be 0..3");
      end
      if (HD == 0 && per_lane(LB, NP) == 0) begin : g_bad_lane
         $error("container wider than a lane without high-density packing");
      end
      if (used_end(NS, NP, LB, HD) + CWW > FB) begin : g_bad_fit
         $error("frame contents exceed L*F*8 bits");
      end
   endgenerate

   logic [NS*NP-1:0] cont_flat;
   logic [FB-1:0]    frame;

   generate
      for (genvar i = 0; i < NS; i++) begin : g_cont
         xfm_container #(
            .N(N), .CS(CS), .CSW(CSW), .CF(CF), .NP(NP)
         ) u_cont (
            .smp  (in_samples[i*N +: N]),
            .ctl  (in_ctrl[i*CSW +: CSW]),
            .cont (cont_flat[i*NP +: NP])
         );
      end
   endgenerate

   xfm_assembler #(
      .NS(NS), .NP(NP), .CS(CS), .CSW(CSW),
      .LB(LB), .FB(FB), .HD(HD), .CWW(CWW)
   ) u_asm (
      .cont_flat (cont_flat),
      .ctl_flat  (in_ctrl),
      .frame     (frame)
   );

   xfm_out_stage #(.W(FB)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (frame),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_lanes)
   );

   p_reset_idle_r10: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

endmodule

// File: tb/xport_frame_mapper_bench.sv
module xport_frame_mapper_bench;
   localparam int CLK_PERIOD = 10;

   int compared   = 0;
   int mismatched = 0;
   logic clk = 1'b0;
   logic rst_n = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // A: no split, in-container control, padded lanes, idle third lane
   logic a_iv = 0, a_ir, a_ov, a_or = 1;
   logic [25:0] a_smp = '0;
   logic [3:0]  a_ctl = '0;
   logic [71:0] a_out;
   xport_frame_mapper #(.M(2),.S(1),.N(13),.CS(2),.L(3),.F(3),.HD(0),.CF(0)) u_xport_frame_mapper (
      .clk(clk), .rst_n(rst_n), .in_valid(a_iv), .in_ready(a_ir),
      .in_samples(a_smp), .in_ctrl(a_ctl), .out_valid(a_ov), .out_ready(a_or), .out_lanes(a_out));

   // B: high-density split, no control bits
   logic b_iv = 0, b_ir, b_ov, b_or = 1;
   logic [23:0] b_smp = '0;
   logic [1:0]  b_ctl = '0;
   logic [23:0] b_out;
   xport_frame_mapper #(.M(1),.S(2),.N(12),.CS(0),.L(3),.F(1),.HD(1),.CF(0)) u_xport_frame_mapper_hd (
      .clk(clk), .rst_n(rst_n), .in_valid(b_iv), .in_ready(b_ir),
      .in_samples(b_smp), .in_ctrl(b_ctl), .out_valid(b_ov), .out_ready(b_or), .out_lanes(b_out));

   // C: no split with lane tail, grouped control word
   logic c_iv = 0, c_ir, c_ov, c_or = 1;
   logic [35:0] c_smp = '0;
   logic [5:0]  c_ctl = '0;
   logic [63:0] c_out;
   xport_frame_mapper #(.M(1),.S(3),.N(12),.CS(2),.L(2),.F(4),.HD(0),.CF(1)) u_xport_frame_mapper_cw (
      .clk(clk), .rst_n(rst_n), .in_valid(c_iv), .in_ready(c_ir),
      .in_samples(c_smp), .in_ctrl(c_ctl), .out_valid(c_ov), .out_ready(c_or), .out_lanes(c_out));

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [71:0] exp_a(logic [12:0] s0, logic [1:0] c0, logic [12:0] s1, logic [1:0] c1);
      return {s0, c0, 1'b0, 8'h00, s1, c1, 1'b0, 8'h00, 24'h0};
   endfunction

   task automatic t_reset();
      @(negedge clk);
      chk("R10 out_valid A in reset", {127'b0, a_ov}, 128'd0);
      chk("R10 out_valid C in reset", {127'b0, c_ov}, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 out_valid A after reset", {127'b0, a_ov}, 128'd0);
      chk("R8 in_ready A idle", {127'b0, a_ir}, 128'd1);
   endtask

   task automatic send_a(logic [12:0] s0, logic [1:0] c0, logic [12:0] s1, logic [1:0] c1);
      a_smp = {s1, s0}; a_ctl = {c1, c0}; a_iv = 1'b1;
      @(negedge clk);
      a_iv = 1'b0;
      chk("R8 out_valid A one edge after accept", {127'b0, a_ov}, 128'd1);
      chk("R1 R2 R3 R6 R7 frame A", {56'b0, a_out}, {56'b0, exp_a(s0, c0, s1, c1)});
   endtask

   task automatic t_default_map();
      send_a(13'h1ABC, 2'b10, 13'h0123, 2'b01);
      send_a(13'h1FFF, 2'b11, 13'h1FFF, 2'b11);
      send_a(13'h0001, 2'b00, 13'h1000, 2'b10);
      @(negedge clk);
      chk("R8 out_valid A drains", {127'b0, a_ov}, 128'd0);
   endtask

   task automatic t_split_hd();
      b_smp = {12'h456, 12'hABC}; b_ctl = 2'b11; b_iv = 1'b1;
      @(negedge clk);
      b_iv = 1'b0;
      chk("R4 R7 split frame B", {104'b0, b_out}, {104'b0, 12'hABC, 12'h456});
      chk("R4 lane1 of B straddles", {120'b0, b_out[15:8]}, {120'b0, 8'hC4});
      b_smp = {12'h456, 12'hABC}; b_ctl = 2'b00; b_iv = 1'b1;
      @(negedge clk);
      b_iv = 1'b0;
      chk("R11 in_ctrl ignored when CS is 0", {104'b0, b_out}, {104'b0, 24'hABC456});
   endtask

   task automatic t_tail_cw();
      c_smp = {12'h333, 12'h222, 12'h111}; c_ctl = {2'b01, 2'b10, 2'b11}; c_iv = 1'b1;
      @(negedge clk);
      c_iv = 1'b0;
      chk("R3 lane0 of C tail padded", {96'b0, c_out[63:32]}, {96'b0, 12'h111, 12'h222, 8'h00});
      chk("R3 R5 lane1 of C with control word", {96'b0, c_out[31:0]},
          {96'b0, 12'h333, 12'h000, 2'b11, 2'b10, 2'b01, 2'b00});
      c_smp = '1; c_ctl = '0; c_iv = 1'b1;
      @(negedge clk);
      c_iv = 1'b0;
      chk("R5 R6 C all-ones samples, zero control", {64'b0, c_out},
          {64'b0, 24'hFFFFFF, 8'h00, 12'hFFF, 20'h0});
   endtask

   task automatic t_backpressure();
      a_or = 1'b0;
      a_smp = {13'h0AAA, 13'h1555}; a_ctl = 4'b0110; a_iv = 1'b1;
      @(negedge clk);
      a_smp = {13'h0F0F, 13'h10F0}; a_ctl = 4'b1001;
      for (int k = 0; k < 3; k++) begin
         chk("R9 held frame A", {56'b0, a_out}, {56'b0, exp_a(13'h1555, 2'b10, 13'h0AAA, 2'b01)});
         chk("R9 in_ready low while stalled", {127'b0, a_ir}, 128'd0);
         chk("R9 out_valid held", {127'b0, a_ov}, 128'd1);
         @(negedge clk);
      end
      a_or = 1'b1;
      @(negedge clk);
      a_iv = 1'b0;
      chk("R8 pending beat lands after release", {56'b0, a_out},
          {56'b0, exp_a(13'h10F0, 2'b01, 13'h0F0F, 2'b10)});
      chk("R8 out_valid after release", {127'b0, a_ov}, 128'd1);
      @(negedge clk);
      chk("R8 drained after release", {127'b0, a_ov}, 128'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      t_reset();
      t_default_map();
      t_split_hd();
      t_tail_cw();
      t_backpressure();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule